// File: doc/BRIEF.md
# ALU Execute Stage with Immediates

This block is the execute step for the eight integer arithmetic and logic opcodes of a small 32-bit processor. On each cycle with `issue_i` high it takes a decoded 3-bit opcode, two mode bits from the instruction's extension byte and three register-field indices. It drives two read addresses to an external 32-entry register file and uses the data that comes back. The second operand can also come from the instruction-stream word that follows the instruction. In that case `extra_word_o` tells the fetch logic in the same cycle to step the program counter by one more word.

Add, subtract, AND, OR and the two shifts return their result through a registered write port to the destination register. Multiply and divide do not use the destination field. They load a dedicated pair of result registers (primary and secondary) held inside the block. The overflow, zero, sign and parity flags follow the primary result of every completed operation. A divide by zero changes no state and gives a one-cycle error strobe.

Top module: `alu_exec_unit`

## Requirements
- R1: Opcodes 0 (add), 1 (subtract), 4 (AND) and 5 (OR) combine operand A (register at `src_a_fld_i`) with operand B. One clock after issue, `rf_we_o` is high for exactly one cycle, `rf_waddr_o` equals `dst_fld_i` and `rf_wdata_o` holds the 32-bit result. Results wrap modulo 2^32.
- R2: For opcodes 0 to 5, `mode_i[0]` = 1 takes operand B from `stream_word_i` and drives `extra_word_o` high in the issue cycle. `mode_i[0]` = 0 takes B from the register at `src_b_fld_i` and keeps `extra_word_o` low. `extra_word_o` is low whenever `issue_i` is low.
- R3: Opcode 6 shifts operand A left by one bit and opcode 7 shifts it right by one bit, both filling with zero. Their result goes to the destination register. `mode_i[0]` and operand B have no effect, and `extra_word_o` stays low.
- R4: `mode_i[1]` = 1 selects two's-complement arithmetic for opcodes 0 to 3. AND, OR and the shifts give the same result in either mode.
- R5: Opcode 2 (multiply) loads the low 32 bits of the 64-bit product into `pair_pri_o` and the high 32 bits into `pair_sec_o`, one clock after issue. It does not assert `rf_we_o`.
- R6: Opcode 3 (divide) loads the quotient into `pair_pri_o` and the remainder into `pair_sec_o`, and does not assert `rf_we_o`. In signed mode the quotient truncates toward zero and the remainder takes the dividend's sign. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R7: A divide whose operand B is zero leaves the pair registers and all flags unchanged and does not assert `rf_we_o`. It raises `div_err_o` for the one cycle after issue.
- R8: After each completed operation, `flag_zero_o` shows whether the primary result is zero and `flag_sign_o` equals its bit 31. `flag_par_o` is 1 when the primary result has an odd number of one bits. The primary result is the written value, or `pair_pri_o` for multiply and divide.
- R9: `flag_ovf_o` is set as follows. Add sets it on carry-out in unsigned mode and on two's-complement overflow in signed mode. Subtract sets it on borrow in unsigned mode and on overflow in signed mode. Multiply sets it when the product does not fit in 32 bits (unsigned or signed). Divide sets it only for the signed most-negative by -1 case. AND and OR clear it. Shift left copies the bit shifted out of bit 31, and shift right copies the bit shifted out of bit 0.
- R10: During and after reset, `rf_we_o`, `div_err_o`, both pair registers and all four flags are zero.
- R11: With `issue_i` low, no output changes except the combinational read addresses.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An ALU instruction is executed this cycle |
| opcode_i | input | 3 | Operation code, 0 to 7 |
| mode_i | input | 2 | Bit 0: immediate operand B; bit 1: signed arithmetic |
| dst_fld_i | input | 5 | Destination register index |
| src_a_fld_i | input | 5 | Register index of operand A |
| src_b_fld_i | input | 5 | Register index of operand B |
| stream_word_i | input | 32 | Instruction-stream word that follows the instruction |
| rf_rdata_a_i | input | 32 | Register file read data, port A |
| rf_rdata_b_i | input | 32 | Register file read data, port B |
| rf_raddr_a_o | output | 5 | Register file read address, port A |
| rf_raddr_b_o | output | 5 | Register file read address, port B |
| extra_word_o | output | 1 | The stream word was consumed as operand B |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write address |
| rf_wdata_o | output | 32 | Register file write data |
| pair_pri_o | output | 32 | Primary pair register (product low or quotient) |
| pair_sec_o | output | 32 | Secondary pair register (product high or remainder) |
| flag_ovf_o | output | 1 | Overflow flag |
| flag_zero_o | output | 1 | Zero flag |
| flag_sign_o | output | 1 | Sign flag |
| flag_par_o | output | 1 | Parity flag (odd count of ones) |
| div_err_o | output | 1 | Divide-by-zero strobe |

## Verification
Each opcode runs in both arithmetic modes, on operands chosen at the wrap points: all-ones plus one, the largest positive plus one, the most negative minus one, and the most negative divided by -1. These operands separate the unsigned and signed overflow rules and the signed and unsigned quotient and remainder. Register-sourced and stream-sourced operand B are mixed, including an immediate divisor, so a wrong operand mux or a wrong `extra_word_o` shows up in the results. A shift with the immediate bit set tests that the bit is ignored. A multiply followed by divides by zero, and idle cycles with live-looking inputs, test that the pair registers and flags stay unchanged.

// File: rtl/alu_exec_pkg.sv
`timescale 1ns/1ps
package alu_exec_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_MUL = 3'd2,
    ALU_DIV = 3'd3,
    ALU_AND = 3'd4,
    ALU_OR  = 3'd5,
    ALU_SHL = 3'd6,
    ALU_SHR = 3'd7
  } alu_op_e;

  localparam int MODE_IMM_BIT    = 0;
  localparam int MODE_SIGNED_BIT = 1;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic sign;
    logic par;
  } alu_flags_t;

  // Operations that take a second operand (and may take it from the stream)
  function automatic logic op_has_second(alu_op_e op);
    return (op != ALU_SHL) && (op != ALU_SHR);
  endfunction

  // Operations whose results go to the dedicated pair registers
  function automatic logic op_is_pair(alu_op_e op);
    return (op == ALU_MUL) || (op == ALU_DIV);
  endfunction

endpackage

// File: rtl/alu_operand_sel.sv
`timescale 1ns/1ps
module alu_operand_sel
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  alu_op_e           op_i,
  input  logic              mode_imm_i,
  input  logic [IDX_W-1:0]  fld_a_i,
  input  logic [IDX_W-1:0]  fld_b_i,
  input  logic [DATA_W-1:0] stream_word_i,
  input  logic [DATA_W-1:0] rdata_a_i,
  input  logic [DATA_W-1:0] rdata_b_i,
  output logic [IDX_W-1:0]  raddr_a_o,
  output logic [IDX_W-1:0]  raddr_b_o,
  output logic [DATA_W-1:0] opnd_a_o,
  output logic [DATA_W-1:0] opnd_b_o,
  output logic              word_taken_o
);

  logic use_stream;

  assign raddr_a_o  = fld_a_i;
  assign raddr_b_o  = fld_b_i;
  assign use_stream = mode_imm_i && op_has_second(op_i);

  always_comb begin
    opnd_a_o = rdata_a_i;
    opnd_b_o = use_stream ? stream_word_i : rdata_b_i;
  end

  assign word_taken_o = issue_i && use_stream;

  AST_SHIFT_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !op_has_second(op_i)) |-> !word_taken_o); // R3

  AST_WORD_FEEDS_B: assert property (@(posedge clk) disable iff (!rst_n)
    word_taken_o |-> (opnd_b_o == stream_word_i)); // R2

endmodule

// File: rtl/alu_compute.sv
`timescale 1ns/1ps
module alu_compute
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] pri_o,
  output logic [DATA_W-1:0] sec_o,
  output logic              ovf_o,
  output logic              div_zero_o
);

  localparam int PROD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  // {ovf, result} for add (sub=0) or subtract (sub=1)
  function automatic logic [DATA_W:0] f_addsub(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b,
                                               input logic sub,
                                               input logic sgn);
    logic [DATA_W-1:0] bb;
    logic [DATA_W:0]   sum;
    logic              ov;
    bb  = sub ? ~b : b;
    sum = {1'b0, a} + {1'b0, bb} + {{DATA_W{1'b0}}, sub};
    if (sgn)
      ov = (a[DATA_W-1] == bb[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
    else
      ov = sub ? ~sum[DATA_W] : sum[DATA_W];
    return {ov, sum[DATA_W-1:0]};
  endfunction

  // {ovf, high, low}
  function automatic logic [PROD_W:0] f_mul(input logic [DATA_W-1:0] a,
                                            input logic [DATA_W-1:0] b,
                                            input logic sgn);
    logic [PROD_W-1:0] xa, xb, p;
    logic              ov;
    xa = {{DATA_W{a[DATA_W-1] & sgn}}, a};
    xb = {{DATA_W{b[DATA_W-1] & sgn}}, b};
    p  = xa * xb;
    if (sgn)
      ov = (p[PROD_W-1:DATA_W] != {DATA_W{p[DATA_W-1]}});
    else
      ov = |p[PROD_W-1:DATA_W];
    return {ov, p};
  endfunction

  // {ovf, remainder, quotient}; zero divisor yields zeros (caller suppresses)
  function automatic logic [PROD_W:0] f_div(input logic [DATA_W-1:0] a,
                                            input logic [DATA_W-1:0] b,
                                            input logic sgn);
    logic [DATA_W-1:0] ma, mb, uq, ur, q, r;
    logic              neg_a, neg_b, ov;
    neg_a = sgn && a[DATA_W-1];
    neg_b = sgn && b[DATA_W-1];
    ma    = neg_a ? -a : a;
    mb    = neg_b ? -b : b;
    if (mb == '0) begin
      uq = '0;
      ur = '0;
    end else begin
      uq = ma / mb;
      ur = ma % mb;
    end
    q  = (neg_a ^ neg_b) ? -uq : uq;
    r  = neg_a ? -ur : ur;
    ov = sgn && (a == MOST_NEG) && (b == {DATA_W{1'b1}});
    return {ov, r, q};
  endfunction

  logic [DATA_W:0] addsub_res;
  logic [PROD_W:0] mul_res;
  logic [PROD_W:0] div_res;

  assign addsub_res = f_addsub(a_i, b_i, (op_i == ALU_SUB), signed_i);
  assign mul_res    = f_mul(a_i, b_i, signed_i);
  assign div_res    = f_div(a_i, b_i, signed_i);
  assign div_zero_o = (op_i == ALU_DIV) && (b_i == '0);

  always_comb begin
    pri_o = '0;
    sec_o = '0;
    ovf_o = 1'b0;
    unique case (op_i)
      ALU_ADD, ALU_SUB: begin
        pri_o = addsub_res[DATA_W-1:0];
        ovf_o = addsub_res[DATA_W];
      end
      ALU_MUL: begin
        pri_o = mul_res[DATA_W-1:0];
        sec_o = mul_res[PROD_W-1:DATA_W];
        ovf_o = mul_res[PROD_W];
      end
      ALU_DIV: begin
        pri_o = div_res[DATA_W-1:0];
        sec_o = div_res[PROD_W-1:DATA_W];
        ovf_o = div_res[PROD_W];
      end
      ALU_AND: pri_o = a_i & b_i;
      ALU_OR:  pri_o = a_i | b_i;
      ALU_SHL: begin
        pri_o = {a_i[DATA_W-2:0], 1'b0};
        ovf_o = a_i[DATA_W-1];
      end
      ALU_SHR: begin
        pri_o = {1'b0, a_i[DATA_W-1:1]};
        ovf_o = a_i[0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_flag_gen.sv
`timescale 1ns/1ps
module alu_flag_gen
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              ovf_i,
  output alu_flags_t        flags_o
);

  // Parity as a running XOR chain, one stage per result bit
  logic [DATA_W-1:0] par_chain;

  assign par_chain[0] = result_i[0];
  for (genvar g = 1; g < DATA_W; g++) begin : g_par
    assign par_chain[g] = par_chain[g-1] ^ result_i[g];
  end

  always_comb begin
    flags_o.ovf  = ovf_i;
    flags_o.zero = (result_i == '0);
    flags_o.sign = result_i[DATA_W-1];
    flags_o.par  = par_chain[DATA_W-1];
  end

endmodule

// File: rtl/alu_exec_unit.sv
`timescale 1ns/1ps
module alu_exec_unit
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [2:0]        opcode_i,
  input  logic [1:0]        mode_i,
  input  logic [IDX_W-1:0]  dst_fld_i,
  input  logic [IDX_W-1:0]  src_a_fld_i,
  input  logic [IDX_W-1:0]  src_b_fld_i,
  input  logic [DATA_W-1:0] stream_word_i,
  input  logic [DATA_W-1:0] rf_rdata_a_i,
  input  logic [DATA_W-1:0] rf_rdata_b_i,
  output logic [IDX_W-1:0]  rf_raddr_a_o,
  output logic [IDX_W-1:0]  rf_raddr_b_o,
  output logic              extra_word_o,
  output logic              rf_we_o,
  output logic [IDX_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic [DATA_W-1:0] pair_pri_o,
  output logic [DATA_W-1:0] pair_sec_o,
  output logic              flag_ovf_o,
  output logic              flag_zero_o,
  output logic              flag_sign_o,
  output logic              flag_par_o,
  output logic              div_err_o
);

  alu_op_e           op;
  logic [DATA_W-1:0] opnd_a, opnd_b;
  logic [DATA_W-1:0] c_pri, c_sec;
  logic              c_ovf, c_div_zero;
  alu_flags_t        c_flags;

  // Named internal events
  logic              ev_pair_load;
  logic              ev_dest_write;
  logic              ev_div_fault;

  logic              we_q, err_q;
  logic [IDX_W-1:0]  waddr_q;
  logic [DATA_W-1:0] wdata_q, pri_q, sec_q;
  alu_flags_t        flags_q;

  assign op = alu_op_e'(opcode_i);

  alu_operand_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_opsel (
    .clk           (clk_i),
    .rst_n         (rst_ni),
    .issue_i       (issue_i),
    .op_i          (op),
    .mode_imm_i    (mode_i[MODE_IMM_BIT]),
    .fld_a_i       (src_a_fld_i),
    .fld_b_i       (src_b_fld_i),
    .stream_word_i (stream_word_i),
    .rdata_a_i     (rf_rdata_a_i),
    .rdata_b_i     (rf_rdata_b_i),
    .raddr_a_o     (rf_raddr_a_o),
    .raddr_b_o     (rf_raddr_b_o),
    .opnd_a_o      (opnd_a),
    .opnd_b_o      (opnd_b),
    .word_taken_o  (extra_word_o)
  );

  alu_compute #(.DATA_W(DATA_W)) u_core (
    .op_i       (op),
    .signed_i   (mode_i[MODE_SIGNED_BIT]),
    .a_i        (opnd_a),
    .b_i        (opnd_b),
    .pri_o      (c_pri),
    .sec_o      (c_sec),
    .ovf_o      (c_ovf),
    .div_zero_o (c_div_zero)
  );

  alu_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .result_i (c_pri),
    .ovf_i    (c_ovf),
    .flags_o  (c_flags)
  );

  assign ev_div_fault  = issue_i && c_div_zero;
  assign ev_pair_load  = issue_i && op_is_pair(op) && !c_div_zero;
  assign ev_dest_write = issue_i && !op_is_pair(op);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      pri_q   <= '0;
      sec_q   <= '0;
      flags_q <= '0;
    end else begin
      we_q  <= ev_dest_write;
      err_q <= ev_div_fault;
      if (ev_dest_write) begin
        waddr_q <= dst_fld_i;
        wdata_q <= c_pri;
      end
      if (ev_pair_load) begin
        pri_q <= c_pri;
        sec_q <= c_sec;
      end
      if (ev_dest_write || ev_pair_load)
        flags_q <= c_flags;
    end
  end

  assign rf_we_o     = we_q;
  assign rf_waddr_o  = waddr_q;
  assign rf_wdata_o  = wdata_q;
  assign pair_pri_o  = pri_q;
  assign pair_sec_o  = sec_q;
  assign div_err_o   = err_q;
  assign flag_ovf_o  = flags_q.ovf;
  assign flag_zero_o = flags_q.zero;
  assign flag_sign_o = flags_q.sign;
  assign flag_par_o  = flags_q.par;

  AST_DEST_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && (opcode_i != 3'd2) && (opcode_i != 3'd3))
      |=> (rf_we_o && (rf_waddr_o == $past(dst_fld_i)))); // R1

  AST_PAIR_NO_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && ((opcode_i == 3'd2) || (opcode_i == 3'd3))) |=> !rf_we_o); // R5

  AST_DIV0_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> ($stable(pair_pri_o) && $stable(pair_sec_o) && !rf_we_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> (!rf_we_o && !div_err_o && $stable(pair_pri_o) && $stable(flag_zero_o))); // R11

  AST_ZERO_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (flag_zero_o == (rf_wdata_o == '0))); // R8

  AST_SIGN_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (flag_sign_o == rf_wdata_o[DATA_W-1])); // R8

endmodule

// File: tb/alu_exec_unit_test.sv
`timescale 1ns/1ps
module alu_exec_unit_test;

  localparam int  NV     = 16;
  localparam int  WD_CYC = 20000;
  localparam longint MAXS = 64'sd2147483647;
  localparam longint MINS = -64'sd2147483648;

  localparam logic [2:0] V_OP [NV] = '{3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3,
                                       3'd3, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd2, 3'd0};
  localparam logic [1:0] V_MD [NV] = '{2'b00, 2'b01, 2'b10, 2'b00, 2'b11, 2'b00, 2'b10, 2'b01,
                                       2'b10, 2'b10, 2'b10, 2'b01, 2'b01, 2'b10, 2'b11, 2'b10};
  localparam logic [31:0] V_A [NV] = '{32'h7, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h5, 32'h80000000,
                                       32'hFFFFFFFF, 32'hFFFFFFFD, 32'd100, 32'hFFFFFFF9,
                                       32'h80000000, 32'h0000F0F0, 32'h12340000, 32'h80000001,
                                       32'h3, 32'h40000000, 32'h80000000};
  localparam logic [31:0] V_B [NV] = '{32'h3, 32'h0, 32'h1, 32'h7, 32'h0, 32'h2, 32'h5, 32'h0,
                                       32'h2, 32'hFFFFFFFF, 32'h0000FF00, 32'h0, 32'h0, 32'h0,
                                       32'h0, 32'h80000000};
  localparam logic [31:0] V_I [NV] = '{32'h0, 32'h1, 32'h0, 32'h0, 32'h1, 32'h0, 32'h0, 32'd7,
                                       32'h0, 32'h0, 32'h0, 32'h00005678, 32'hDEADBEEF, 32'h0,
                                       32'h4, 32'h0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [2:0]  opcode = '0;
  logic [1:0]  mode = '0;
  logic [4:0]  fd = '0, fa = '0, fb = '0;
  logic [31:0] stream = '0;
  logic [31:0] rf [32];
  logic [4:0]  raddr_a, raddr_b, waddr;
  logic        extra_word, we, ovf, zf, sf, pf, derr;
  logic [31:0] wdata, ppri, psec;
  logic [31:0] rdata_a, rdata_b;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign rdata_a = rf[raddr_a];
  assign rdata_b = rf[raddr_b];

  alu_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .opcode_i(opcode), .mode_i(mode),
    .dst_fld_i(fd), .src_a_fld_i(fa), .src_b_fld_i(fb), .stream_word_i(stream),
    .rf_rdata_a_i(rdata_a), .rf_rdata_b_i(rdata_b),
    .rf_raddr_a_o(raddr_a), .rf_raddr_b_o(raddr_b), .extra_word_o(extra_word),
    .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata),
    .pair_pri_o(ppri), .pair_sec_o(psec),
    .flag_ovf_o(ovf), .flag_zero_o(zf), .flag_sign_o(sf), .flag_par_o(pf),
    .div_err_o(derr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model written with wide signed integers: {ovf, secondary, primary}
  function automatic logic [64:0] ref_calc(input logic [2:0] op, input logic sgn,
                                           input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, sr, sm;
    longint unsigned ua, ub, ur;
    logic [31:0] p, s;
    logic o;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'd0, a};
    ub = {32'd0, b};
    p = '0; s = '0; o = 1'b0;
    case (op)
      3'd0: if (sgn) begin sr = sa + sb; p = sr[31:0]; o = (sr > MAXS) || (sr < MINS); end
            else begin ur = ua + ub; p = ur[31:0]; o = (ur > 64'hFFFFFFFF); end
      3'd1: if (sgn) begin sr = sa - sb; p = sr[31:0]; o = (sr > MAXS) || (sr < MINS); end
            else begin p = a - b; o = (a < b); end
      3'd2: if (sgn) begin sr = sa * sb; p = sr[31:0]; s = sr[63:32]; o = (sr > MAXS) || (sr < MINS); end
            else begin ur = ua * ub; p = ur[31:0]; s = ur[63:32]; o = (s != 0); end
      3'd3: if (b != 0) begin
              if (sgn) begin sr = sa / sb; sm = sa % sb; p = sr[31:0]; s = sm[31:0]; o = (sr > MAXS); end
              else begin p = a / b; s = a % b; end
            end
      3'd4: p = a & b;
      3'd5: p = a | b;
      3'd6: begin p = a << 1; o = a[31]; end
      default: begin p = a >> 1; o = a[0]; end
    endcase
    return {o, s, p};
  endfunction

  function automatic logic odd_ones(input logic [31:0] v);
    int n = 0;
    for (int k = 0; k < 32; k++) n += int'(v[k]);
    return (n % 2) == 1;
  endfunction

  task automatic check_flags(input string tag, input logic [31:0] p, input logic o);
    chk({tag, " R9"}, "ovf", {31'd0, ovf}, {31'd0, o});
    chk("R8", "zero", {31'd0, zf}, {31'd0, (p == 0)});
    chk("R8", "sign", {31'd0, sf}, {31'd0, p[31]});
    chk("R8", "parity", {31'd0, pf}, {31'd0, odd_ones(p)});
  endtask

  initial begin
    #(WD_CYC * 5);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [64:0] r;
    logic [31:0] snap_pri, snap_sec, snap_wd, opb;
    logic [3:0]  snap_fl;
    string tg;
    for (int k = 0; k < 32; k++) rf[k] = 32'h0;
    repeat (4) @(negedge clk);
    // R10: reset state (checked while reset is held and after release)
    chk("R10", "we in reset", {31'd0, we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "we", {31'd0, we}, 32'd0);
    chk("R10", "div_err", {31'd0, derr}, 32'd0);
    chk("R10", "pair_pri", ppri, 32'd0);
    chk("R10", "pair_sec", psec, 32'd0);
    chk("R10", "flags", {28'd0, ovf, zf, sf, pf}, 32'd0);
    chk("R2", "extra_word idle", {31'd0, extra_word}, 32'd0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [4:0] f1, f2, f3;
      logic want_word;
      f1 = 5'((i * 7 + 9) % 32);
      f2 = 5'((i * 3 + 1) % 32);
      f3 = 5'((i * 5 + 2) % 32);
      @(negedge clk);
      rf[f2] = V_A[i];
      rf[f3] = V_B[i];
      opcode = V_OP[i]; mode = V_MD[i];
      fd = f1; fa = f2; fb = f3;
      stream = V_I[i];
      issue = 1'b1;
      want_word = V_MD[i][0] && (V_OP[i] < 3'd6);
      opb = want_word ? V_I[i] : V_B[i];
      r = ref_calc(V_OP[i], V_MD[i][1], V_A[i], opb);
      case (V_OP[i])
        3'd2: tg = "R5";
        3'd3: tg = "R6";
        3'd6, 3'd7: tg = "R3";
        default: tg = "R1";
      endcase
      if (V_MD[i][1]) tg = {tg, " R4"};
      #1;
      chk((V_OP[i] >= 3'd6) ? "R3" : "R2", "extra_word", {31'd0, extra_word}, {31'd0, want_word});
      @(posedge clk);
      #1 issue = 1'b0;
      @(negedge clk);
      if (V_OP[i] == 3'd2 || V_OP[i] == 3'd3) begin
        chk(tg, "pair_pri", ppri, r[31:0]);
        chk(tg, "pair_sec", psec, r[63:32]);
        chk(tg, "no dest write", {31'd0, we}, 32'd0);
      end else begin
        chk(tg, "we", {31'd0, we}, 32'd1);
        chk(tg, "waddr", {27'd0, waddr}, {27'd0, f1});
        chk(tg, "wdata", wdata, r[31:0]);
      end
      check_flags(tg, r[31:0], r[64]);
    end

    // R11: inputs active but issue low
    @(negedge clk);
    snap_pri = ppri; snap_sec = psec; snap_wd = wdata; snap_fl = {ovf, zf, sf, pf};
    rf[1] = 32'h11; rf[2] = 32'h22;
    opcode = 3'd0; mode = 2'b01; fd = 5'd9; fa = 5'd1; fb = 5'd2; stream = 32'h99;
    repeat (3) @(negedge clk);
    chk("R11", "we", {31'd0, we}, 32'd0);
    chk("R11", "div_err", {31'd0, derr}, 32'd0);
    chk("R11", "wdata held", wdata, snap_wd);
    chk("R11", "pair_pri held", ppri, snap_pri);
    chk("R11", "pair_sec held", psec, snap_sec);
    chk("R11", "flags held", {28'd0, ovf, zf, sf, pf}, {28'd0, snap_fl});
    chk("R2", "extra_word with issue low", {31'd0, extra_word}, 32'd0);

    // R7: multiply, then divide by zero from a register
    rf[4] = 32'd6; rf[5] = 32'd7;
    opcode = 3'd2; mode = 2'b00; fa = 5'd4; fb = 5'd5; issue = 1'b1;
    @(posedge clk); #1 issue = 1'b0;
    @(negedge clk);
    chk("R5", "mul 6*7", ppri, 32'd42);
    snap_fl = {ovf, zf, sf, pf};
    rf[6] = 32'd9; rf[7] = 32'd0;
    opcode = 3'd3; mode = 2'b00; fa = 5'd6; fb = 5'd7; issue = 1'b1;
    @(posedge clk); #1 issue = 1'b0;
    @(negedge clk);
    chk("R7", "div_err", {31'd0, derr}, 32'd1);
    chk("R7", "pair_pri held", ppri, 32'd42);
    chk("R7", "pair_sec held", psec, 32'd0);
    chk("R7", "flags held", {28'd0, ovf, zf, sf, pf}, {28'd0, snap_fl});
    chk("R7", "no dest write", {31'd0, we}, 32'd0);
    @(negedge clk);
    chk("R7", "strobe one cycle", {31'd0, derr}, 32'd0);

    // R7: signed divide by a zero immediate
    rf[6] = 32'hFFFFFFF0;
    opcode = 3'd3; mode = 2'b11; stream = 32'd0; issue = 1'b1;
    #1 chk("R2", "extra_word div imm", {31'd0, extra_word}, 32'd1);
    @(posedge clk); #1 issue = 1'b0;
    @(negedge clk);
    chk("R7", "signed div_err", {31'd0, derr}, 32'd1);
    chk("R7", "signed pair_pri held", ppri, 32'd42);
    @(negedge clk);
    chk("R7", "signed strobe ends", {31'd0, derr}, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule